// File: doc/BRIEF.md
# Mesh Shift Network with Programmable Edges

This block holds a rectangular grid of one-bit cells, one bit-plane, and moves the whole plane one cell toward north, south, east or west in a single clock cycle. Each cell takes its next value from its nearest neighbour on the side the data comes from. The block is meant for a bit-serial processor array, where neighbour exchange is the only data movement inside the array.

A small topology register controls what enters along the array borders. The top/bottom setting and the left/right setting are independent. The top/bottom edges are either open, so zeros enter, or joined, so the plane wraps vertically. The left/right edges have four settings. Open fills with zeros. Cylindrical wraps each row onto itself. Open spiral chains the end of each row into the start of the next, so the plane behaves like one long shift line. Closed spiral also joins the last cell back to the first, so the plane forms one ring. Software loads a plane in parallel, picks a topology and a direction, and pulses the shift enable once for each step.

Cell (r, c) is bit r*COLS + c of the plane buses. Row 0 is the north edge and column 0 is the west edge. The grid defaults to 8 by 8.

Top module: `meshShiftNet`

## Requirements
- R1: While reset is active and on the first cycle after it, every plane bit is 0. The topology register resets to 3'b000, so both edge settings are open until the first write.
- R2: When loadEn is high at a rising edge, plane takes loadData on that edge. This holds even when shiftEn is also high.
- R3: When loadEn and shiftEn are both low, plane keeps its value, whatever the other inputs do.
- R4: dir encodes 2'b00 north, 2'b01 south, 2'b10 east, 2'b11 west. A north shift moves cell (r+1, c) into (r, c). A south shift moves cell (r-1, c) into (r, c). With topology bit 0 clear, the row that enters takes zeros.
- R5: With topology bit 0 set, a north shift loads row ROWS-1 from row 0 and a south shift loads row 0 from row ROWS-1, column by column.
- R6: With topology bits 2:1 = 2'b00, an east shift moves (r, c-1) into (r, c) and zero-fills column 0. A west shift moves (r, c+1) into (r, c) and zero-fills column COLS-1.
- R7: With bits 2:1 = 2'b01 (cylindrical), an east shift loads (r, 0) from (r, COLS-1) and a west shift loads (r, COLS-1) from (r, 0), within the same row.
- R8: With bits 2:1 = 2'b10 (open spiral), an east shift loads (r, 0) from (r-1, COLS-1) and a west shift loads (r, COLS-1) from (r+1, 0). Cell (0, 0) on east and cell (ROWS-1, COLS-1) on west take 0.
- R9: With bits 2:1 = 2'b11 (closed spiral), the plane is one ring. East loads (0, 0) from (ROWS-1, COLS-1) and west loads (ROWS-1, COLS-1) from (0, 0). ROWS*COLS east shifts restore the original plane.
- R10: topoWr captures topoData into the topology register on the edge. A shift in the same cycle still uses the previous setting, and the new setting governs the next shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadEn | input | 1 | Parallel load strobe, has priority over shiftEn |
| loadData | input | ROWS*COLS | Plane to load, bit r*COLS+c is cell (r, c) |
| shiftEn | input | 1 | One-step shift strobe |
| dir | input | 2 | Shift direction: 0 north, 1 south, 2 east, 3 west |
| topoWr | input | 1 | Topology register write strobe |
| topoData | input | 3 | Bit 0 top/bottom joined; bits 2:1 left/right mode |
| plane | output | ROWS*COLS | Current bit-plane |

## Verification
Some properties hold on every cycle, and the assertions check those. A load always captures its data, even against a shift. An idle cycle leaves the plane unchanged. A topology write lands on the next edge. Any shift through a wrapping border conserves the number of set bits, and a shift across an open left/right border can never add ones. The exact placement of each bit at each border needs the bench's scenarios. These include each spiral's row-to-row chaining, the zeros entering at the chain ends, the old-setting rule for a shift issued together with a topology write, and a full ring rotation that returns the original plane. The bench checks these against an arithmetic source-index model over every topology setting, every direction and many patterns.

// File: rtl/meshPkg.sv
package meshPkg;

  typedef enum logic [1:0] {
    DIR_NORTH = 2'b00,
    DIR_SOUTH = 2'b01,
    DIR_EAST  = 2'b10,
    DIR_WEST  = 2'b11
  } dirT;

  typedef enum logic [1:0] {
    LR_OPEN    = 2'b00,
    LR_CYL     = 2'b01,
    LR_OSPIRAL = 2'b10,
    LR_CSPIRAL = 2'b11
  } lrModeT;

  // Packed so that lr lands on bits 2:1 and tbJoin on bit 0
  typedef struct packed {
    lrModeT lr;
    logic   tbJoin;
  } topoT;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic shift;
    dirT  dir;
  } stepT;

endpackage

// File: rtl/meshCtrl.sv
module meshCtrl
  import meshPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadEn,
  input  logic       shiftEn,
  input  logic [1:0] dir,
  input  logic       topoWr,
  input  logic [2:0] topoData,
  output stepT       step,
  output topoT       topoQ
);

  // Topology register: the new value governs shifts after the write edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      topoQ <= '{lr: LR_OPEN, tbJoin: 1'b0};
    end else if (topoWr) begin
      topoQ <= topoT'(topoData);
    end
  end

  // A load wins over a shift in the same cycle
  always_comb begin
    step.load  = loadEn;
    step.shift = shiftEn & ~loadEn;
    step.dir   = dirT'(dir);
  end

endmodule

// File: rtl/meshCell.sv
module meshCell
  import meshPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  stepT step,
  input  logic loadBit,
  input  logic fromN,
  input  logic fromS,
  input  logic fromE,
  input  logic fromW,
  output logic q
);

  logic nextBit;

  // Data moving north comes up from the south neighbour, and so on
  always_comb begin
    unique case (step.dir)
      DIR_NORTH: nextBit = fromS;
      DIR_SOUTH: nextBit = fromN;
      DIR_EAST:  nextBit = fromW;
      DIR_WEST:  nextBit = fromE;
      default:   nextBit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q <= 1'b0;
    end else if (step.load) begin
      q <= loadBit;
    end else if (step.shift) begin
      q <= nextBit;
    end
  end

endmodule

// File: rtl/meshPlane.sv
module meshPlane
  import meshPkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  stepT                 step,
  input  topoT                 topo,
  input  logic [ROWS*COLS-1:0] loadData,
  output logic [ROWS*COLS-1:0] plane
);

  localparam int N = ROWS * COLS;

  logic [N-1:0] q;
  logic         wrapLr;
  logic         chainLr;
  logic         ringLr;

  assign plane   = q;
  assign wrapLr  = (topo.lr == LR_CYL);
  assign chainLr = (topo.lr == LR_OSPIRAL) || (topo.lr == LR_CSPIRAL);
  assign ringLr  = (topo.lr == LR_CSPIRAL);

  for (genvar r = 0; r < ROWS; r++) begin : gRow
    for (genvar c = 0; c < COLS; c++) begin : gCol
      localparam int IDX    = r * COLS + c;
      localparam int ROWBEG = r * COLS;
      localparam int ROWEND = r * COLS + COLS - 1;

      logic fromN, fromS, fromE, fromW;

      // Vertical neighbours
      if (r > 0) begin : gHasN
        assign fromN = q[IDX - COLS];
      end else begin : gTopEdge
        assign fromN = topo.tbJoin & q[(ROWS - 1) * COLS + c];
      end

      if (r < ROWS - 1) begin : gHasS
        assign fromS = q[IDX + COLS];
      end else begin : gBotEdge
        assign fromS = topo.tbJoin & q[c];
      end

      // Horizontal neighbours, west side
      if (c > 0) begin : gHasW
        assign fromW = q[IDX - 1];
      end else if (r > 0) begin : gWestChain
        assign fromW = (wrapLr & q[ROWEND]) | (chainLr & q[IDX - 1]);
      end else begin : gWestCorner
        assign fromW = (wrapLr & q[ROWEND]) | (ringLr & q[N - 1]);
      end

      // Horizontal neighbours, east side
      if (c < COLS - 1) begin : gHasE
        assign fromE = q[IDX + 1];
      end else if (r < ROWS - 1) begin : gEastChain
        assign fromE = (wrapLr & q[ROWBEG]) | (chainLr & q[IDX + 1]);
      end else begin : gEastCorner
        assign fromE = (wrapLr & q[ROWBEG]) | (ringLr & q[0]);
      end

      meshCell u_cell (
        .clk     (clk),
        .rstN    (rstN),
        .step    (step),
        .loadBit (loadData[IDX]),
        .fromN   (fromN),
        .fromS   (fromS),
        .fromE   (fromE),
        .fromW   (fromW),
        .q       (q[IDX])
      );
    end
  end

endmodule

// File: rtl/meshShiftNet.sv
module meshShiftNet
  import meshPkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 loadEn,
  input  logic [ROWS*COLS-1:0] loadData,
  input  logic                 shiftEn,
  input  logic [1:0]           dir,
  input  logic                 topoWr,
  input  logic [2:0]           topoData,
  output logic [ROWS*COLS-1:0] plane
);

  stepT step;
  topoT topoQ;

  meshCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .loadEn   (loadEn),
    .shiftEn  (shiftEn),
    .dir      (dir),
    .topoWr   (topoWr),
    .topoData (topoData),
    .step     (step),
    .topoQ    (topoQ)
  );

  meshPlane #(
    .ROWS (ROWS),
    .COLS (COLS)
  ) u_plane (
    .clk      (clk),
    .rstN     (rstN),
    .step     (step),
    .topo     (topoQ),
    .loadData (loadData),
    .plane    (plane)
  );

endmodule

// File: rtl/meshShiftChk.sv
module meshShiftChk #(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 loadEn,
  input logic [ROWS*COLS-1:0] loadData,
  input logic                 shiftEn,
  input logic [1:0]           dir,
  input logic                 topoWr,
  input logic [2:0]           topoData,
  input logic [2:0]           topoQ,
  input logic [ROWS*COLS-1:0] plane
);

  logic doShift;
  logic horiz;
  assign doShift = shiftEn && !loadEn;
  assign horiz   = dir[1];

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> plane == $past(loadData)) else $error("load not captured"); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && !shiftEn) |=> $stable(plane)) else $error("plane moved while idle"); // R3

  AST_TB_WRAP_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (doShift && !horiz && topoQ[0]) |=> $countones(plane) == $countones($past(plane)))
    else $error("vertical wrap lost bits"); // R5

  AST_LR_OPEN_NO_GROWTH: assert property (@(posedge clk) disable iff (!rstN)
    (doShift && horiz && topoQ[2:1] == 2'b00) |=> $countones(plane) <= $countones($past(plane)))
    else $error("open edge created bits"); // R6

  AST_CYL_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (doShift && horiz && topoQ[2:1] == 2'b01) |=> $countones(plane) == $countones($past(plane)))
    else $error("cylinder lost bits"); // R7

  AST_RING_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (doShift && horiz && topoQ[2:1] == 2'b11) |=> $countones(plane) == $countones($past(plane)))
    else $error("ring lost bits"); // R9

  AST_TOPO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    topoWr |=> topoQ == $past(topoData)) else $error("topology write missed"); // R10

endmodule

bind meshShiftNet meshShiftChk #(
  .ROWS (ROWS),
  .COLS (COLS)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .loadEn   (loadEn),
  .loadData (loadData),
  .shiftEn  (shiftEn),
  .dir      (dir),
  .topoWr   (topoWr),
  .topoData (topoData),
  .topoQ    (topoQ),
  .plane    (plane)
);

// File: tb/meshShiftNet_tb.sv
`timescale 1ns/1ps
module meshShiftNet_tb;

  localparam int ROWS = 4;
  localparam int COLS = 5;
  localparam int N    = ROWS * COLS;

  logic         clk = 1'b0;
  logic         rstN;
  logic         loadEn;
  logic [N-1:0] loadData;
  logic         shiftEn;
  logic [1:0]   dir;
  logic         topoWr;
  logic [2:0]   topoData;
  logic [N-1:0] plane;

  int vecs = 0;
  int bad  = 0;
  bit done = 0;

  always #4 clk = ~clk;

  meshShiftNet #(.ROWS(ROWS), .COLS(COLS)) u_dut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadData(loadData),
    .shiftEn(shiftEn), .dir(dir), .topoWr(topoWr), .topoData(topoData),
    .plane(plane)
  );

  // Reference: each cell's source index from row/column arithmetic
  function automatic logic [N-1:0] refShift(input logic [N-1:0] p,
                                            input logic [1:0] d,
                                            input logic [2:0] t);
    logic [N-1:0] o;
    int r, c, sr, lin;
    bit ok;
    o = '0;
    for (int i = 0; i < N; i++) begin
      r = i / COLS; c = i % COLS; ok = 1; lin = 0;
      case (d)
        2'd0: begin
          sr = r + 1;
          if (sr == ROWS) begin if (t[0]) sr = 0; else ok = 0; end
          lin = sr * COLS + c;
        end
        2'd1: begin
          sr = r - 1;
          if (sr < 0) begin if (t[0]) sr = ROWS - 1; else ok = 0; end
          lin = sr * COLS + c;
        end
        2'd2: begin
          if (c > 0) lin = i - 1;
          else case (t[2:1])
            2'd0: ok = 0;
            2'd1: lin = i + COLS - 1;
            2'd2: begin lin = i - 1; if (lin < 0) ok = 0; end
            default: lin = (i + N - 1) % N;
          endcase
        end
        default: begin
          if (c < COLS - 1) lin = i + 1;
          else case (t[2:1])
            2'd0: ok = 0;
            2'd1: lin = i - (COLS - 1);
            2'd2: begin lin = i + 1; if (lin >= N) ok = 0; end
            default: lin = (i + 1) % N;
          endcase
        end
      endcase
      o[i] = ok ? p[lin] : 1'b0;
    end
    return o;
  endfunction

  function automatic string tagFor(input logic [1:0] d, input logic [2:0] t);
    if (d < 2) return t[0] ? "R5" : "R4";
    case (t[2:1])
      2'd0:    return "R6";
      2'd1:    return "R7";
      2'd2:    return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input logic [N-1:0] exp, input string tag);
    vecs++;
    if (plane !== exp) begin
      bad++;
      $display("FAIL %s: plane=%h expected=%h", tag, plane, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idleInputs();
    loadEn = 0; shiftEn = 0; topoWr = 0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [N-1:0] pat, exp, q;
    rstN = 0; loadEn = 0; shiftEn = 0; topoWr = 0;
    loadData = '0; dir = 2'd0; topoData = 3'd0;
    repeat (3) tick();
    check('0, "R1 during reset");
    rstN = 1;
    tick();
    check('0, "R1 after reset");

    // R1: topology resets to open/open
    pat = N'(32'hA5C3_9E17);
    loadEn = 1; loadData = pat; tick();
    loadEn = 0; shiftEn = 1; dir = 2'd2; tick();
    exp = refShift(pat, 2'd2, 3'b000);
    check(exp, "R1 default east open");
    dir = 2'd0; tick();
    exp = refShift(exp, 2'd0, 3'b000);
    check(exp, "R1 default north open");

    // R2: load wins over shift
    q = N'(32'h0F0F_3C3C);
    loadEn = 1; shiftEn = 1; dir = 2'd3; loadData = q; tick();
    check(q, "R2 load priority");

    // R3: idle hold while other inputs move
    idleInputs();
    for (int k = 0; k < 3; k++) begin
      loadData = ~q; dir = 2'(k);
      tick();
      check(q, "R3 hold");
    end

    // R10: topology write and shift in same cycle use the old setting
    pat = N'(32'h0008_4211);
    loadEn = 1; loadData = pat; tick();
    loadEn = 0; topoWr = 1; topoData = 3'b111; shiftEn = 1; dir = 2'd2; tick();
    exp = refShift(pat, 2'd2, 3'b000);
    check(exp, "R10 old setting on write cycle");
    topoWr = 0; tick();
    exp = refShift(exp, 2'd2, 3'b111);
    check(exp, "R10 new setting next shift");
    dir = 2'd1; tick();
    exp = refShift(exp, 2'd1, 3'b111);
    check(exp, "R10 new vertical setting");
    idleInputs(); tick();

    // R9: a full ring rotation restores the plane
    pat = N'(32'h000C_0A31);
    loadEn = 1; loadData = pat; topoWr = 1; topoData = 3'b110; tick();
    loadEn = 0; topoWr = 0; shiftEn = 1; dir = 2'd2;
    for (int k = 0; k < N; k++) tick();
    check(pat, "R9 ring rotation");
    idleInputs(); tick();

    // Sweep: every topology, every direction, many patterns, two steps each
    for (int t = 0; t < 8; t++) begin
      for (int d = 0; d < 4; d++) begin
        for (int k = 0; k < N + 6; k++) begin
          if (k < N) pat = N'(1) << k;
          else if (k == N) pat = '1;
          else if (k == N + 1) pat = {(N+1)/2{2'b01}};
          else pat = N'((k * 32'h9E37_79B1) ^ (k << 7) ^ (t * 32'h0101_0101));
          loadEn = 1; loadData = pat; topoWr = 1; topoData = 3'(t); tick();
          loadEn = 0; topoWr = 0; shiftEn = 1; dir = 2'(d); tick();
          exp = refShift(pat, 2'(d), 3'(t));
          check(exp, tagFor(2'(d), 3'(t)));
          tick();
          exp = refShift(exp, 2'(d), 3'(t));
          check(exp, tagFor(2'(d), 3'(t)));
          shiftEn = 0;
        end
      end
    end

    done = 1;
    summary();
    $finish;
  end

endmodule